// File: doc/BRIEF.md
# Fused Multiply-Add Special-Operand Resolver

This combinational unit sits in front of a single-precision fused multiply-add datapath that computes `z + x*y`, or `z - x*y` when the product is negated. It looks at the three operands, sorts each into zero, subnormal, normal, infinity, quiet NaN or signalling NaN, and decides whether the outcome is fixed by special-value rules alone. When it is, the unit raises `decided`, presents the final 32-bit word on `spec_result`, and sets `invalid_op` for invalid-operation cases.

When `decided` is low, `spec_result` and `invalid_op` are zero. The arithmetic datapath then takes the same operands unchanged and performs the real multiply, align, add and round.

The resolution steps run in a fixed order:

1. NaN selection.
2. Infinity-times-zero.
3. Infinite product.
4. Zero product.
5. Finite product against an infinite addend.

Each step is a named rule in the `res_rule_e` enumeration: `RL_NONE`, `RL_NAN_PASS`, `RL_NAN_QUIET`, `RL_INVALID`, `RL_INF_PROD`, `RL_TAKE_Z` and `RL_ZERO_RM`. One `unique case` turns the chosen rule into the outputs.

Top module: `fma_special_resolver`

## Requirements
- R1: If any operand is a signalling NaN (exponent all ones, fraction nonzero, fraction bit 22 clear), the first one in the order z, x, y is returned with fraction bit 22 set, its sign and other bits kept, with `decided`=1 and `invalid_op`=1.
- R2: With no signalling NaN present, the first quiet NaN (exponent all ones, fraction bit 22 set) in the order z, x, y is returned unchanged with `decided`=1 and `invalid_op`=0; this wins over every rule below.
- R3: An infinity multiplied by a zero, in either order, gives the default NaN 0x7FC00000 with `invalid_op`=1.
- R4: The effective product sign is sign(x) XOR sign(y), inverted when `neg_prod`=1. If the product is infinite and z is an infinity of the other sign, the result is 0x7FC00000 with `invalid_op`=1.
- R5: If the product is infinite and R4 does not apply, the result is an infinity carrying the effective product sign (0x7F800000 or 0xFF800000) with `invalid_op`=0.
- R6: If the product is finite and nonzero and z is an infinity, the result is z.
- R7: If the product is zero and z is a zero whose sign equals the effective product sign, the result is z.
- R8: If the product is zero and z is a zero of the other sign, the result is +0 (0x00000000). In rounding mode `rnd_mode`=2'b11 (toward minus infinity) it is -0 (0x80000000); the other modes are 00 nearest-even, 01 toward zero and 10 toward plus infinity.
- R9: If the product is zero and z is finite and nonzero, normal or subnormal, the result is z.
- R10: When no rule above applies (finite nonzero product and finite z), `decided`=0, `spec_result`=0 and `invalid_op`=0. `invalid_op` is never 1 while `decided` is 0.
- R11: Subnormal operands count as finite and nonzero. A subnormal times an infinity follows R5, and a subnormal product with a zero z goes to the datapath.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_z | input | 32 | Addend z |
| op_x | input | 32 | Multiplicand x |
| op_y | input | 32 | Multiplier y |
| neg_prod | input | 1 | Negate the product (multiply-subtract) |
| rnd_mode | input | 2 | Rounding mode: 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| decided | output | 1 | Result is fully fixed by special-value rules |
| spec_result | output | 32 | Special result when `decided` is 1, else zero |
| invalid_op | output | 1 | Invalid-operation flag |

## Verification
The bench builds the unit with its default parameters, an 8-bit exponent and a 23-bit fraction, which is the single-precision format that all the expected words are written in. With these widths the bench can reach the boundaries that matter:

- signalling-NaN quieting through fraction bit 22;
- subnormals that differ from zero only in the lowest fraction bit;
- infinities whose sign clashes with a negated product;
- the signed-zero choice, which depends on every rounding-mode code.

// File: rtl/fma_pkg.sv
package fma_pkg;

    typedef enum logic [2:0] {
        CL_ZERO,
        CL_DNORM,
        CL_NORM,
        CL_INF,
        CL_QNAN,
        CL_SNAN
    } op_class_e;

    typedef enum logic [2:0] {
        RL_NONE,
        RL_NAN_PASS,
        RL_NAN_QUIET,
        RL_INVALID,
        RL_INF_PROD,
        RL_TAKE_Z,
        RL_ZERO_RM
    } res_rule_e;

    localparam logic [1:0] RM_NEAREST = 2'b00;
    localparam logic [1:0] RM_TOZERO  = 2'b01;
    localparam logic [1:0] RM_UP      = 2'b10;
    localparam logic [1:0] RM_DOWN    = 2'b11;

    localparam int N_OPS = 3;
    localparam int IDX_Z = 0;
    localparam int IDX_X = 1;
    localparam int IDX_Y = 2;

endpackage

// File: rtl/fma_op_classify.sv
module fma_op_classify
    import fma_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] operand,
    output op_class_e             cls,
    output logic                  sign
);
    localparam int FP_W = EXP_W + FRAC_W + 1;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    assign sign   = operand[FP_W-1];
    assign exp_f  = operand[FP_W-2 -: EXP_W];
    assign frac_f = operand[FRAC_W-1:0];

    always_comb begin
        if (exp_f == '0) begin
            cls = (frac_f == '0) ? CL_ZERO : CL_DNORM;
        end else if (exp_f == '1) begin
            if (frac_f == '0)
                cls = CL_INF;
            else if (frac_f[FRAC_W-1])
                cls = CL_QNAN;
            else
                cls = CL_SNAN;
        end else begin
            cls = CL_NORM;
        end
    end
endmodule

// File: rtl/fma_nan_select.sv
module fma_nan_select
    import fma_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] ops [N_OPS],
    input  op_class_e             cls [N_OPS],
    output logic                  nan_any,
    output logic                  nan_sig,
    output logic [EXP_W+FRAC_W:0] nan_val
);
    localparam int FP_W = EXP_W + FRAC_W + 1;

    logic [N_OPS-1:0] is_s;
    logic [N_OPS-1:0] is_q;

    for (genvar g = 0; g < N_OPS; g++) begin : g_flag
        assign is_s[g] = (cls[g] == CL_SNAN);
        assign is_q[g] = (cls[g] == CL_QNAN);
    end

    // lowest index wins: z, then x, then y; signalling group first
    always_comb begin
        nan_any = 1'b0;
        nan_sig = 1'b0;
        nan_val = '0;
        for (int i = N_OPS - 1; i >= 0; i--) begin
            if (is_q[i]) begin
                nan_any = 1'b1;
                nan_val = ops[i];
            end
        end
        for (int i = N_OPS - 1; i >= 0; i--) begin
            if (is_s[i]) begin
                nan_any = 1'b1;
                nan_sig = 1'b1;
                nan_val = ops[i] | (FP_W'(1) << (FRAC_W - 1));
            end
        end
    end
endmodule

// File: rtl/fma_special_rules.sv
module fma_special_rules
    import fma_pkg::*;
(
    input  op_class_e cls_z,
    input  op_class_e cls_x,
    input  op_class_e cls_y,
    input  logic      sgn_z,
    input  logic      sgn_x,
    input  logic      sgn_y,
    input  logic      neg_prod,
    input  logic      nan_any,
    input  logic      nan_sig,
    output res_rule_e rule,
    output logic      prod_sign
);
    logic x_zero, y_zero, x_inf, y_inf;
    logic prod_zero, prod_inf, z_inf, z_zero;

    assign prod_sign = sgn_x ^ sgn_y ^ neg_prod;
    assign x_zero    = (cls_x == CL_ZERO);
    assign y_zero    = (cls_y == CL_ZERO);
    assign x_inf     = (cls_x == CL_INF);
    assign y_inf     = (cls_y == CL_INF);
    assign prod_zero = x_zero | y_zero;
    assign prod_inf  = x_inf | y_inf;
    assign z_inf     = (cls_z == CL_INF);
    assign z_zero    = (cls_z == CL_ZERO);

    always_comb begin
        if (nan_any)
            rule = nan_sig ? RL_NAN_QUIET : RL_NAN_PASS;
        else if (prod_inf && prod_zero)
            rule = RL_INVALID;
        else if (prod_inf)
            rule = (z_inf && (sgn_z != prod_sign)) ? RL_INVALID : RL_INF_PROD;
        else if (prod_zero) begin
            if (z_zero && (sgn_z != prod_sign))
                rule = RL_ZERO_RM;
            else
                rule = RL_TAKE_Z;
        end else if (z_inf)
            rule = RL_TAKE_Z;
        else
            rule = RL_NONE;
    end
endmodule

// File: rtl/fma_special_resolver.sv
module fma_special_resolver
    import fma_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] op_z,
    input  logic [EXP_W+FRAC_W:0] op_x,
    input  logic [EXP_W+FRAC_W:0] op_y,
    input  logic                  neg_prod,
    input  logic [1:0]            rnd_mode,
    output logic                  decided,
    output logic [EXP_W+FRAC_W:0] spec_result,
    output logic                  invalid_op
);
    localparam int FP_W = EXP_W + FRAC_W + 1;
    localparam logic [FP_W-1:0] DEFAULT_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [FP_W-1:0] POS_INF = {1'b0, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};

    logic [FP_W-1:0] ops [N_OPS];
    op_class_e       cls [N_OPS];
    logic [N_OPS-1:0] sgn;

    assign ops[IDX_Z] = op_z;
    assign ops[IDX_X] = op_x;
    assign ops[IDX_Y] = op_y;

    for (genvar g = 0; g < N_OPS; g++) begin : g_cls
        fma_op_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_cls (
            .operand (ops[g]),
            .cls     (cls[g]),
            .sign    (sgn[g])
        );
    end

    logic            nan_any, nan_sig;
    logic [FP_W-1:0] nan_val;

    fma_nan_select #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_nan (
        .ops     (ops),
        .cls     (cls),
        .nan_any (nan_any),
        .nan_sig (nan_sig),
        .nan_val (nan_val)
    );

    res_rule_e rule;
    logic      prod_sign;

    fma_special_rules i_rules (
        .cls_z     (cls[IDX_Z]),
        .cls_x     (cls[IDX_X]),
        .cls_y     (cls[IDX_Y]),
        .sgn_z     (sgn[IDX_Z]),
        .sgn_x     (sgn[IDX_X]),
        .sgn_y     (sgn[IDX_Y]),
        .neg_prod  (neg_prod),
        .nan_any   (nan_any),
        .nan_sig   (nan_sig),
        .rule      (rule),
        .prod_sign (prod_sign)
    );

    always_comb begin
        decided     = 1'b1;
        invalid_op  = 1'b0;
        spec_result = '0;
        unique case (rule)
            RL_NONE: begin
                decided = 1'b0;
            end
            RL_NAN_PASS: begin
                spec_result = nan_val;
            end
            RL_NAN_QUIET: begin
                spec_result = nan_val;
                invalid_op  = 1'b1;
            end
            RL_INVALID: begin
                spec_result = DEFAULT_NAN;
                invalid_op  = 1'b1;
            end
            RL_INF_PROD: begin
                spec_result = POS_INF | {prod_sign, {(FP_W-1){1'b0}}};
            end
            RL_TAKE_Z: begin
                spec_result = op_z;
            end
            RL_ZERO_RM: begin
                spec_result = {(rnd_mode == RM_DOWN), {(FP_W-1){1'b0}}};
            end
            default: begin
                decided = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/fma_resolver_chk.sv
module fma_resolver_chk #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input logic [EXP_W+FRAC_W:0] op_z,
    input logic [EXP_W+FRAC_W:0] op_x,
    input logic [EXP_W+FRAC_W:0] op_y,
    input logic                  decided,
    input logic [EXP_W+FRAC_W:0] spec_result,
    input logic                  invalid_op
);
    localparam int FP_W = EXP_W + FRAC_W + 1;

    function automatic logic f_snan(input logic [FP_W-1:0] v);
        return (v[FP_W-2 -: EXP_W] == '1) && (v[FRAC_W-1:0] != '0) && !v[FRAC_W-1];
    endfunction
    function automatic logic f_qnan(input logic [FP_W-1:0] v);
        return (v[FP_W-2 -: EXP_W] == '1) && v[FRAC_W-1];
    endfunction

    logic any_s, any_q;
    assign any_s = f_snan(op_z) | f_snan(op_x) | f_snan(op_y);
    assign any_q = f_qnan(op_z) | f_qnan(op_x) | f_qnan(op_y);

    always_comb begin
        // R10
        invalid_needs_decided_chk: assert (!invalid_op || decided);
        // R1
        snan_raises_chk: assert (!any_s || (invalid_op && f_qnan(spec_result)));
        // R2
        qnan_passes_chk: assert (any_s || !any_q ||
            (!invalid_op && (spec_result == op_z || spec_result == op_x ||
                             spec_result == op_y)));
        // R10
        open_result_zero_chk: assert (decided || (spec_result == '0));
    end
endmodule

bind fma_special_resolver fma_resolver_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_chk (
    .op_z        (op_z),
    .op_x        (op_x),
    .op_y        (op_y),
    .decided     (decided),
    .spec_result (spec_result),
    .invalid_op  (invalid_op)
);

// File: tb/test_fma_special_resolver.sv
module test_fma_special_resolver;

    logic        clk = 1'b0;
    logic [31:0] op_z = '0, op_x = '0, op_y = '0;
    logic        neg_prod = 1'b0;
    logic [1:0]  rnd_mode = 2'b00;
    logic        decided;
    logic [31:0] spec_result;
    logic        invalid_op;

    int total = 0;
    int bad   = 0;
    logic driving_done = 1'b0;

    typedef struct {
        logic        dec;
        logic [31:0] res;
        logic        inv;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    always #10 clk = ~clk;

    fma_special_resolver i_fma_special_resolver (
        .op_z        (op_z),
        .op_x        (op_x),
        .op_y        (op_y),
        .neg_prod    (neg_prod),
        .rnd_mode    (rnd_mode),
        .decided     (decided),
        .spec_result (spec_result),
        .invalid_op  (invalid_op)
    );

    task automatic compare(input exp_t e);
        total++;
        if (decided !== e.dec || spec_result !== e.res || invalid_op !== e.inv) begin
            bad++;
            $display("FAIL %s: got dec=%0b res=%08h inv=%0b exp dec=%0b res=%08h inv=%0b",
                     e.tag, decided, spec_result, invalid_op, e.dec, e.res, e.inv);
        end
    endtask

    task automatic drive(input logic [31:0] z, input logic [31:0] x, input logic [31:0] y,
                         input logic ng, input logic [1:0] rm,
                         input logic d, input logic [31:0] r, input logic iv,
                         input string tag);
        exp_t e;
        @(posedge clk);
        op_z = z; op_x = x; op_y = y; neg_prod = ng; rnd_mode = rm;
        e.dec = d; e.res = r; e.inv = iv; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // monitor: pops at the falling edge after each drive
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) compare(sb_q.pop_front());
        end
    end

    initial begin
        // initial inputs all zero: +0 + (+0 * +0) -> +0 (R7)
        #5;
        begin
            exp_t e0;
            e0.dec = 1'b1; e0.res = 32'h0; e0.inv = 1'b0; e0.tag = "R7 idle";
            compare(e0);
        end
        // R1
        drive(32'h7FC00001, 32'h7F800005, 32'hFF800003, 0, 0, 1, 32'h7FC00005, 1, "R1 x snan beats z qnan");
        drive(32'h3F800000, 32'h3F800000, 32'hFF800003, 0, 0, 1, 32'hFFC00003, 1, "R1 y snan sign kept");
        drive(32'h7F800009, 32'h7F800005, 32'h7F800001, 0, 0, 1, 32'h7FC00009, 1, "R1 z snan first");
        // R2
        drive(32'h3F800000, 32'h7FC00001, 32'hFFC00002, 0, 0, 1, 32'h7FC00001, 0, "R2 x qnan before y");
        drive(32'hFFC00007, 32'h7F800000, 32'h00000000, 0, 0, 1, 32'hFFC00007, 0, "R2 z qnan beats inf*0");
        // R3
        drive(32'h3F800000, 32'h7F800000, 32'h00000000, 0, 0, 1, 32'h7FC00000, 1, "R3 inf*0");
        drive(32'hFF800000, 32'h00000000, 32'hFF800000, 0, 0, 1, 32'h7FC00000, 1, "R3 0*-inf");
        // R4
        drive(32'hFF800000, 32'h7F800000, 32'h3F800000, 0, 0, 1, 32'h7FC00000, 1, "R4 inf - inf");
        drive(32'h7F800000, 32'h7F800000, 32'h3F800000, 1, 0, 1, 32'h7FC00000, 1, "R4 negated clash");
        // R5
        drive(32'hFF800000, 32'h7F800000, 32'hBF800000, 0, 0, 1, 32'hFF800000, 0, "R5 same sign inf");
        drive(32'h3F800000, 32'hFF800000, 32'h40000000, 1, 0, 1, 32'h7F800000, 0, "R5 negated sign");
        // R11
        drive(32'h3F800000, 32'h00000001, 32'h7F800000, 0, 0, 1, 32'h7F800000, 0, "R11 subnormal*inf");
        // R6
        drive(32'hFF800000, 32'h40000000, 32'hBF800000, 0, 0, 1, 32'hFF800000, 0, "R6 z inf");
        // R7
        drive(32'h80000000, 32'h00000000, 32'hBF800000, 0, 0, 1, 32'h80000000, 0, "R7 -0 + -0");
        drive(32'h80000000, 32'h00000000, 32'h3F800000, 1, 0, 1, 32'h80000000, 0, "R7 negated same");
        // R8
        drive(32'h80000000, 32'h00000000, 32'h3F800000, 0, 2'b00, 1, 32'h00000000, 0, "R8 nearest +0");
        drive(32'h80000000, 32'h00000000, 32'h3F800000, 0, 2'b11, 1, 32'h80000000, 0, "R8 down -0");
        drive(32'h00000000, 32'h00000000, 32'h3F800000, 1, 2'b11, 1, 32'h80000000, 0, "R8 negated down");
        drive(32'h00000000, 32'h00000000, 32'h3F800000, 1, 2'b10, 1, 32'h00000000, 0, "R8 up +0");
        drive(32'h00000000, 32'h00000000, 32'h3F800000, 1, 2'b01, 1, 32'h00000000, 0, "R8 tozero +0");
        // R9
        drive(32'hBF800000, 32'h00000000, 32'h40000000, 0, 0, 1, 32'hBF800000, 0, "R9 z normal");
        drive(32'h80000001, 32'h40000000, 32'h00000000, 0, 2'b11, 1, 32'h80000001, 0, "R9 z subnormal");
        // R10
        drive(32'h3F800000, 32'h3F800000, 32'h40000000, 0, 0, 0, 32'h00000000, 0, "R10 datapath case");
        drive(32'h00000000, 32'h00000001, 32'h00000001, 0, 2'b11, 0, 32'h00000000, 0, "R11 subnormal product");
        @(posedge clk);
        @(posedge clk);
        driving_done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (driving_done);
            end
            begin
                repeat (10000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog: got timeout exp completion");
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule